// File: doc/BRIEF.md
# Parallel unsigned multiplier with (4,2) counter reduction

This block multiplies two unsigned operands of `W` bits and delivers the full `2W`-bit product. It forms every AND-gate partial product at once. The partial-product rows are reduced in levels, and each level feeds groups of four rows through a row of (4,2) counters. Every counter is made of two full adders. It passes one carry sideways to the counter of the next column on the same row, and it sends a second carry down to the next level. Each level halves the number of rows. When two rows remain, a Kogge-Stone prefix adder produces the result.

The parameter `OUT_REG` chooses between a purely combinational product and a product captured in a register. The register has an asynchronous active-low reset. `W` must be a power of two no smaller than 4, and elaboration stops otherwise. The default of 8 gives two reduction levels. A width of 4 gives one reduction level.

Top module: `cmp42_mult`

## Requirements
- R1: `product` equals the unsigned product `op_a * op_b` over all `2W` bits for every operand pair (all 65,536 pairs at W = 8).
- R2: With `OUT_REG = 0` the product is combinational. It is valid in the same cycle the operands are applied, and `clk` and `rst_n` have no effect on it.
- R3: With `OUT_REG = 1` the operands present at a rising edge of `clk` determine `product` from just after that edge until the next rising edge.
- R4: With `OUT_REG = 1`, driving `rst_n` low clears `product` to 0 at once, without waiting for a clock edge, and keeps it at 0 while `rst_n` stays low. The first rising edge after release loads a fresh product.
- R5: A zero in either operand gives a product of 0.
- R6: Both operands at all ones give `(2^W-1)^2` with no carry lost in the top columns (0xFE01 at W = 8).
- R7: The smallest configuration, W = 4, uses a single reduction level and gives the correct 8-bit product for all 256 operand pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| op_a | input | W | Unsigned multiplicand |
| op_b | input | W | Unsigned multiplier |
| product | output | 2W | Unsigned product |

## Verification
On every cycle, the assertions check the following. In the registered variant, the output matches the operands from the previous edge and stays cleared during reset. In the combinational variant, the output matches the present operands. In both variants, the zero and all-ones corner cases hold. Only the bench scenarios show three further points. The first is that every operand pair, including the single-level W = 4 configuration, reduces correctly. The second is that an asynchronous reset arriving between edges clears the output at once. The third is that the combinational variant ignores reset.

// File: rtl/cmp42_pkg.sv
package cmp42_pkg;

   // true when v is a nonzero power of two
   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

   // reduction levels needed to bring W rows down to two
   function automatic int unsigned red_levels(input int unsigned w);
      return $clog2(w) - 1;
   endfunction

   // index of the first row of level l in the flat row store
   function automatic int unsigned row_base(input int unsigned w, input int unsigned l);
      return 2 * w - 2 * (w >> l);
   endfunction

endpackage

// File: rtl/cmp42_cell.sv
// (4,2) counter: two chained full adders.
// cx leaves sideways to the next column of the same row and does not depend on ci.
// co goes down to the next reduction level.
module cmp42_cell (
   input  logic x0,
   input  logic x1,
   input  logic x2,
   input  logic x3,
   input  logic ci,
   output logic s,
   output logic co,
   output logic cx
);
   logic s1;

   assign s1 = x0 ^ x1 ^ x2;
   assign cx = (x0 & x1) | (x0 & x2) | (x1 & x2);
   assign s  = s1 ^ x3 ^ ci;
   assign co = (s1 & x3) | (s1 & ci) | (x3 & ci);
endmodule

// File: rtl/cmp42_row.sv
// One row of (4,2) counters across N columns: four rows in, a sum row and a carry row out.
module cmp42_row #(
   parameter int unsigned N = 16
) (
   input  logic [N-1:0] r0,
   input  logic [N-1:0] r1,
   input  logic [N-1:0] r2,
   input  logic [N-1:0] r3,
   output logic [N-1:0] sum_o,
   output logic [N-1:0] car_o
);
   logic [N-1:0] lat;      // sideways carry entering each column
   logic [N-1:0] cx_w;
   logic [N-1:0] co_w;
   logic [1:0]   unused_msb;

   assign lat        = {cx_w[N-2:0], 1'b0};
   assign car_o      = {co_w[N-2:0], 1'b0};
   assign unused_msb = {co_w[N-1], cx_w[N-1]};   // beyond the product width

   for (genvar i = 0; i < N; i++) begin : g_col
      cmp42_cell u_cell (
         .x0(r0[i]),
         .x1(r1[i]),
         .x2(r2[i]),
         .x3(r3[i]),
         .ci(lat[i]),
         .s (sum_o[i]),
         .co(co_w[i]),
         .cx(cx_w[i])
      );
   end
endmodule

// File: rtl/cmp42_ks_add.sv
// Kogge-Stone prefix adder, carry-out dropped. N must be a power of two.
module cmp42_ks_add #(
   parameter int unsigned N = 16
) (
   input  logic [N-1:0] x,
   input  logic [N-1:0] y,
   output logic [N-1:0] s
);
   localparam int unsigned LG = $clog2(N);

   logic [N-1:0] hp;
   logic [N-1:0] gk [LG+1];
   logic [N-1:0] pk [LG];
   logic         unused_cout;

   assign hp    = x ^ y;
   assign gk[0] = x & y;
   assign pk[0] = hp;

   for (genvar k = 0; k < LG; k++) begin : g_stage
      localparam int unsigned D = 1 << k;
      for (genvar i = 0; i < N; i++) begin : g_bit
         if (i >= D) begin : g_mrg
            assign gk[k+1][i] = gk[k][i] | (pk[k][i] & gk[k][i-D]);
            if (k + 1 < LG) begin : g_p
               assign pk[k+1][i] = pk[k][i] & pk[k][i-D];
            end
         end else begin : g_cpy
            assign gk[k+1][i] = gk[k][i];
            if (k + 1 < LG) begin : g_p
               assign pk[k+1][i] = pk[k][i];
            end
         end
      end
   end

   assign s           = hp ^ {gk[LG][N-2:0], 1'b0};
   assign unused_cout = gk[LG][N-1];
endmodule

// File: rtl/cmp42_mult.sv
module cmp42_mult
   import cmp42_pkg::*;
#(
   parameter int unsigned W       = 8,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [W-1:0]   op_a,
   input  logic [W-1:0]   op_b,
   output logic [2*W-1:0] product
);
   localparam int unsigned P    = 2 * W;
   localparam int unsigned NLVL = red_levels(W);
   localparam int unsigned TOT  = row_base(W, NLVL) + 2;

   if (!is_pow2(W) || W < 4) begin : g_bad_w
      $error("cmp42_mult: W must be a power of two of at least 4");
   end

   // flat store: level l occupies W>>l rows starting at row_base(W,l)
   logic [P-1:0] rw [TOT];
   logic [P-1:0] sum_w;

   for (genvar j = 0; j < W; j++) begin : g_pp
      assign rw[j] = P'(op_a & {W{op_b[j]}}) << j;
   end

   for (genvar l = 1; l <= NLVL; l++) begin : g_lvl
      localparam int unsigned SRC = row_base(W, l - 1);
      localparam int unsigned DST = row_base(W, l);
      localparam int unsigned NG  = (W >> l) / 2;
      for (genvar g = 0; g < NG; g++) begin : g_grp
         cmp42_row #(.N(P)) u_row (
            .r0   (rw[SRC + 4*g]),
            .r1   (rw[SRC + 4*g + 1]),
            .r2   (rw[SRC + 4*g + 2]),
            .r3   (rw[SRC + 4*g + 3]),
            .sum_o(rw[DST + 2*g]),
            .car_o(rw[DST + 2*g + 1])
         );
      end
   end

   cmp42_ks_add #(.N(P)) u_cpa (
      .x(rw[TOT-2]),
      .y(rw[TOT-1]),
      .s(sum_w)
   );

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) product <= '0;
         else        product <= sum_w;
      end
   end else begin : g_comb
      logic unused_ctl;
      assign unused_ctl = clk ^ rst_n;
      assign product    = sum_w;
   end
endmodule

// File: rtl/cmp42_mult_chk.sv
module cmp42_mult_chk #(
   parameter int unsigned W       = 8,
   parameter bit          OUT_REG = 1'b1
) (
   input logic           clk,
   input logic           rst_n,
   input logic [W-1:0]   op_a,
   input logic [W-1:0]   op_b,
   input logic [2*W-1:0] product
);
   localparam int unsigned P    = 2 * W;
   localparam logic [W-1:0] ONES = '1;
   localparam logic [P-1:0] FULL = P'(ONES) * P'(ONES);

   if (OUT_REG) begin : g_reg
      logic armed;   // previous edge saw reset released
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) armed <= 1'b0;
         else        armed <= 1'b1;
      end

      AST_REG_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
         armed |-> product == P'($past(op_a)) * P'($past(op_b))); // R3

      AST_RST_CLEAR: assert property (@(posedge clk)
         !rst_n |-> product == '0); // R4

      AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
         (armed && ($past(op_a) == '0 || $past(op_b) == '0)) |-> product == '0); // R5

      AST_FULL_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
         (armed && $past(op_a) == ONES && $past(op_b) == ONES) |-> product == FULL); // R6
   end else begin : g_comb
      AST_COMB_PRODUCT: assert property (@(posedge clk)
         product == P'(op_a) * P'(op_b)); // R2

      AST_ZERO_OPERAND: assert property (@(posedge clk)
         (op_a == '0 || op_b == '0) |-> product == '0); // R5

      AST_FULL_SCALE: assert property (@(posedge clk)
         (op_a == ONES && op_b == ONES) |-> product == FULL); // R6
   end
endmodule

bind cmp42_mult cmp42_mult_chk #(.W(W), .OUT_REG(OUT_REG)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .op_a   (op_a),
   .op_b   (op_b),
   .product(product)
);

// File: tb/cmp42_mult_bench.sv
module cmp42_mult_bench;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b1;
   logic [7:0]  a = '0, b = '0;
   logic [3:0]  a4 = '0, b4 = '0;
   logic [15:0] p_reg, p_comb;
   logic [7:0]  p_w4;

   int checks = 0;
   int errors = 0;

   always #(CLK_P/2) clk = ~clk;

   cmp42_mult #(.W(8), .OUT_REG(1'b1)) u_cmp42_mult (
      .clk(clk), .rst_n(rst_n), .op_a(a), .op_b(b), .product(p_reg));

   cmp42_mult #(.W(8), .OUT_REG(1'b0)) u_cmp42_mult_comb (
      .clk(clk), .rst_n(rst_n), .op_a(a), .op_b(b), .product(p_comb));

   cmp42_mult #(.W(4), .OUT_REG(1'b0)) u_cmp42_mult_w4 (
      .clk(clk), .rst_n(rst_n), .op_a(a4), .op_b(b4), .product(p_w4));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic string tag_of(input logic [7:0] x, input logic [7:0] y);
      if (x == 0 || y == 0)          return "R5";
      if (x == 8'hFF && y == 8'hFF)  return "R6";
      return "R1";
   endfunction

   initial begin
      logic [15:0] prev_exp;
      string       prev_tag;
      prev_exp = '0;
      prev_tag = "";
      #1 rst_n = 1'b0;
      a = 8'hA5; b = 8'h3C;
      repeat (3) @(negedge clk);
      chk("R4 reset holds zero", 32'(p_reg), 32'h0);
      chk("R2 comb ignores reset", 32'(p_comb), 32'(16'(8'hA5) * 16'(8'h3C)));
      rst_n = 1'b1;

      for (int i = 0; i < 65536; i++) begin
         @(negedge clk);
         if (i > 0) chk({prev_tag, " R3 registered"}, 32'(p_reg), 32'(prev_exp));
         a = i[15:8];
         b = i[7:0];
         if (i < 256) begin
            a4 = i[7:4];
            b4 = i[3:0];
         end
         #1;
         prev_exp = 16'(a) * 16'(b);
         prev_tag = tag_of(a, b);
         chk({prev_tag, " R2 comb"}, 32'(p_comb), 32'(prev_exp));
         if (i < 256) chk("R7 width 4", 32'(p_w4), 32'(8'(a4) * 8'(b4)));
      end
      @(negedge clk);
      chk({prev_tag, " R3 registered last"}, 32'(p_reg), 32'(prev_exp));

      // asynchronous clear between edges, then reload after release
      a = 8'hFF; b = 8'hFF;
      @(posedge clk); #2;
      chk("R6 registered full scale", 32'(p_reg), 32'hFE01);
      rst_n = 1'b0;
      #1;
      chk("R4 async clear", 32'(p_reg), 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R4 reload after release", 32'(p_reg), 32'hFE01);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_P * 150000);
      errors++;
      $display("FAIL watchdog expired R1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule